// File: doc/BRIEF.md
# MESIF Snooping Line-State Controller

This block holds the coherence state of a single cache line for one cache on a snooping bus. It uses five states: Modified, Exclusive, Shared, Invalid and Forward. Processor requests (read, write, evict, demote) arrive on one side. Snooped transactions from other caches (read, read-exclusive, upgrade) arrive on the other. From these the block decides whether to raise a bus request, whether to answer a snoop, and whether memory must be written.

Exactly one clean copy, the one in Forward, answers a snooped read. Shared copies only report that they exist. The Forward role moves to the most recent reader. A dirty or exclusive owner that is snooped by a read supplies the data itself and keeps the Forward role. The snoop responses are combinational, so several instances can sit on one bus and be sampled by the requester in its grant cycle.

Top module: `mesif_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (code 0). The state codes are I=0, S=1, E=2, F=3, M=4. A line in I drives none of `snp_shared`, `snp_supply` or `mem_wb`.
- R2: A snooped read (snoop op 1) to a line in F asserts `snp_shared` and `snp_supply`, and the line becomes S on the next edge. A snooped read to a line in S asserts `snp_shared` only, never `snp_supply`, and the line stays in S.
- R3: A snooped read to a line in E or M asserts `snp_shared`, `snp_supply` and `snp_keep_fwd`, and the line becomes F. In M the same cycle also asserts `mem_wb`.
- R4: A processor read (cpu op 0) to a line in I raises `bus_req_valid` with bus op read (1). The request is held until the cycle in which `bus_gnt` is high, and `cpu_ack` is given in that cycle. The line then installs as E if `bus_shared_in` is low, as S if both `bus_shared_in` and `bus_keep_fwd_in` are high, and as F if only `bus_shared_in` is high.
- R5: A processor write (cpu op 1) to a line in E or M is acknowledged at once with no bus request, and the line ends in M. A write to a line in S or F requests an upgrade (bus op 3). A write to a line in I requests a read-exclusive (bus op 2). Both complete to M on the grant cycle.
- R6: A snooped read-exclusive (2) or upgrade (3) moves S, F or E to I. In M it asserts `snp_supply` and then moves to I. None of these asserts `mem_wb`.
- R7: A processor evict (cpu op 2) is acknowledged at once and leaves the line in I. It asserts `mem_wb` only when the line was in M; evicting an F line writes nothing.
- R8: A processor demote (cpu op 3) moves F to S with no bus request. In any other state it is acknowledged with no change of state.
- R9: While `snp_valid` is high, `cpu_ack` stays low and the snoop alone decides the next state. A pending upgrade whose line is invalidated by a snoop is reissued as a read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present, held until `cpu_ack` |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 demote |
| cpu_ack | output | 1 | Processor request completes this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | 1 read, 2 read-exclusive, 3 upgrade |
| bus_gnt | input | 1 | One-cycle grant of this block's request |
| bus_shared_in | input | 1 | Another cache holds the line (grant cycle) |
| bus_keep_fwd_in | input | 1 | A dirty or exclusive owner keeps the forwarder role (grant cycle) |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_op | input | 2 | Snooped op, same codes as `bus_req_op` |
| snp_shared | output | 1 | This cache holds a valid copy (snooped read) |
| snp_supply | output | 1 | This cache drives the line data |
| snp_keep_fwd | output | 1 | This cache stays the forwarder after a snooped read |
| mem_wb | output | 1 | Write the line back to memory |
| line_state | output | 3 | Current coherence state |

## Verification
A processor request and a snoop can arrive in the same cycle. The bench provokes this in two ways. In one, a write to a Shared line meets a snooped read-exclusive. In the other, a read hit on a Modified line meets a snooped read. It then checks that the processor is not acknowledged and that the snoop response and next state follow the snoop alone. In the write case it also checks that the held request is reissued as a read-exclusive and completes to M on the grant that follows.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_F = 3'd3,
        ST_M = 3'd4
    } line_st_t;

    typedef enum logic [1:0] {
        CPU_RD = 2'd0,
        CPU_WR = 2'd1,
        CPU_EV = 2'd2,
        CPU_DM = 2'd3
    } cpu_op_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_UPG  = 2'd3
    } bus_op_t;

    typedef struct packed {
        logic     shared;
        logic     supply;
        logic     keep_fwd;
        logic     wb;
        line_st_t nxt;
    } snp_resp_t;

    typedef struct packed {
        logic     ack;
        logic     req;
        bus_op_t  op;
        logic     wb;
        logic     upd;
        line_st_t nxt;
    } cpu_resp_t;

    function automatic logic is_valid(line_st_t s);
        return s != ST_I;
    endfunction

    function automatic line_st_t fill_state(logic shared_in, logic keep_fwd_in);
        if (!shared_in)  return ST_E;
        if (keep_fwd_in) return ST_S;
        return ST_F;
    endfunction

endpackage

// File: rtl/mesif_snoop_resp.sv
module mesif_snoop_resp
    import mesif_pkg::*;
(
    input  line_st_t  st,
    input  logic      snp_valid,
    input  bus_op_t   snp_op,
    output snp_resp_t resp
);
    always_comb begin
        resp     = '0;
        resp.nxt = st;
        if (snp_valid) begin
            unique case (snp_op)
                BUS_RD: begin
                    unique case (st)
                        ST_S: resp.shared = 1'b1;
                        ST_F: begin
                            resp.shared = 1'b1;
                            resp.supply = 1'b1;
                            resp.nxt    = ST_S;
                        end
                        ST_E, ST_M: begin
                            resp.shared   = 1'b1;
                            resp.supply   = 1'b1;
                            resp.keep_fwd = 1'b1;
                            resp.wb       = (st == ST_M);
                            resp.nxt      = ST_F;
                        end
                        default: ;
                    endcase
                end
                BUS_RDX, BUS_UPG: begin
                    if (is_valid(st)) begin
                        resp.supply = (st == ST_M);
                        resp.nxt    = ST_I;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesif_cpu_side.sv
module mesif_cpu_side
    import mesif_pkg::*;
(
    input  line_st_t  st,
    input  logic      cpu_valid,
    input  cpu_op_t   cpu_op,
    input  logic      snp_valid,
    input  logic      bus_gnt,
    input  logic      bus_shared_in,
    input  logic      bus_keep_fwd_in,
    output cpu_resp_t resp
);
    logic need_bus;

    always_comb begin
        need_bus = cpu_valid &&
                   (((cpu_op == CPU_RD) && (st == ST_I)) ||
                    ((cpu_op == CPU_WR) && (st == ST_I || st == ST_S || st == ST_F)));

        resp     = '0;
        resp.nxt = st;
        resp.req = need_bus;
        if (need_bus)
            resp.op = (cpu_op == CPU_RD) ? BUS_RD : ((st == ST_I) ? BUS_RDX : BUS_UPG);
        else
            resp.op = BUS_NONE;

        resp.ack = cpu_valid && !snp_valid && (need_bus ? bus_gnt : 1'b1);

        if (resp.ack) begin
            resp.upd = 1'b1;
            unique case (cpu_op)
                CPU_RD: if (st == ST_I) resp.nxt = fill_state(bus_shared_in, bus_keep_fwd_in);
                CPU_WR: resp.nxt = ST_M;
                CPU_EV: begin
                    resp.nxt = ST_I;
                    resp.wb  = (st == ST_M);
                end
                CPU_DM: if (st == ST_F) resp.nxt = ST_S;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
    import mesif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_valid,
    input  logic [1:0] cpu_op,
    output logic       cpu_ack,
    output logic       bus_req_valid,
    output logic [1:0] bus_req_op,
    input  logic       bus_gnt,
    input  logic       bus_shared_in,
    input  logic       bus_keep_fwd_in,
    input  logic       snp_valid,
    input  logic [1:0] snp_op,
    output logic       snp_shared,
    output logic       snp_supply,
    output logic       snp_keep_fwd,
    output logic       mem_wb,
    output logic [2:0] line_state
);
    line_st_t  st_q, st_d;
    snp_resp_t s_resp;
    cpu_resp_t c_resp;
    logic      snoop_act;

    assign snoop_act = snp_valid && !bus_gnt;

    mesif_snoop_resp u_snoop (
        .st        (st_q),
        .snp_valid (snoop_act),
        .snp_op    (bus_op_t'(snp_op)),
        .resp      (s_resp)
    );

    mesif_cpu_side u_cpu (
        .st              (st_q),
        .cpu_valid       (cpu_valid),
        .cpu_op          (cpu_op_t'(cpu_op)),
        .snp_valid       (snoop_act),
        .bus_gnt         (bus_gnt),
        .bus_shared_in   (bus_shared_in),
        .bus_keep_fwd_in (bus_keep_fwd_in),
        .resp            (c_resp)
    );

    always_comb begin
        if (snoop_act)       st_d = s_resp.nxt;
        else if (c_resp.upd) st_d = c_resp.nxt;
        else                 st_d = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_I;
        else     st_q <= st_d;
    end

    assign cpu_ack       = c_resp.ack;
    assign bus_req_valid = c_resp.req;
    assign bus_req_op    = c_resp.op;
    assign snp_shared    = s_resp.shared;
    assign snp_supply    = s_resp.supply;
    assign snp_keep_fwd  = s_resp.keep_fwd;
    assign mem_wb        = s_resp.wb | c_resp.wb;
    assign line_state    = st_q;
endmodule

// File: rtl/mesif_line_chk.sv
module mesif_line_chk
    import mesif_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] cpu_op,
    input logic       cpu_ack,
    input logic       bus_req_valid,
    input logic [1:0] bus_req_op,
    input logic       bus_gnt,
    input logic       snp_valid,
    input logic [1:0] snp_op,
    input logic       snp_shared,
    input logic       snp_supply,
    input logic       snp_keep_fwd,
    input logic       mem_wb,
    input logic [2:0] line_state
);
    logic snp_rd, snp_inv;
    assign snp_rd  = snp_valid && !bus_gnt && (snp_op == BUS_RD);
    assign snp_inv = snp_valid && !bus_gnt && (snp_op == BUS_RDX || snp_op == BUS_UPG);

    assert_invalid_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (line_state == ST_I) |-> (!snp_shared && !snp_supply && !mem_wb));

    assert_shared_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (snp_rd && line_state == ST_S) |-> (snp_shared && !snp_supply));

    assert_fwd_handoff_R2: assert property (@(posedge clk) disable iff (rst)
        (snp_rd && line_state == ST_F) |=> (line_state == ST_S));

    assert_dirty_to_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        (snp_rd && line_state == ST_M) |-> (mem_wb && snp_supply && snp_keep_fwd));

    assert_write_ends_m_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && cpu_op == CPU_WR) |=> (line_state == ST_M));

    assert_upgrade_from_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_op == BUS_UPG) |-> (line_state == ST_S || line_state == ST_F));

    assert_snoop_inval_R6: assert property (@(posedge clk) disable iff (rst)
        snp_inv |=> (line_state == ST_I));

    assert_evict_to_i_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && cpu_op == CPU_EV) |=> (line_state == ST_I));

    assert_snoop_blocks_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !bus_gnt) |-> !cpu_ack);
endmodule

bind mesif_line_ctrl mesif_line_chk u_chk (.*);

// File: tb/mesif_line_ctrl_tb.sv
module mesif_line_ctrl_tb;
    import mesif_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_valid = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic       cpu_ack;
    logic       bus_req_valid;
    logic [1:0] bus_req_op;
    logic       bus_gnt = 1'b0;
    logic       bus_shared_in = 1'b0;
    logic       bus_keep_fwd_in = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = 2'd0;
    logic       snp_shared, snp_supply, snp_keep_fwd, mem_wb;
    logic [2:0] line_state;

    always #5 clk = ~clk;

    mesif_line_ctrl u_dut (.*);

    typedef struct {
        string      tag;
        logic [2:0] st;
        logic       sh, sup, kf, wb, breq;
        logic [1:0] bop;
        logic       ack;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Monitor: compares mid-cycle, after the driver's inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [9:0] act, ex;
                e   = exp_q.pop_front();
                act = {line_state, snp_shared, snp_supply, snp_keep_fwd, mem_wb, bus_req_valid, bus_req_op};
                ex  = {e.st, e.sh, e.sup, e.kf, e.wb, e.breq, e.bop};
                checks++;
                if (act !== ex || cpu_ack !== e.ack) begin
                    errors++;
                    $display("FAIL %s: actual st=%0d sh=%b sup=%b kf=%b wb=%b breq=%b bop=%0d ack=%b expected st=%0d sh=%b sup=%b kf=%b wb=%b breq=%b bop=%0d ack=%b",
                        e.tag, line_state, snp_shared, snp_supply, snp_keep_fwd, mem_wb, bus_req_valid, bus_req_op, cpu_ack,
                        e.st, e.sh, e.sup, e.kf, e.wb, e.breq, e.bop, e.ack);
                end
            end
        end
    end

    // Driver: one cycle of stimulus plus the expected outputs for that cycle
    task automatic cyc(input logic cv, input logic [1:0] cop,
                       input logic sv, input logic [1:0] sop,
                       input logic g, input logic shin, input logic kfin,
                       input string tag, input logic [2:0] st,
                       input logic sh, input logic sup, input logic kf, input logic wb,
                       input logic breq, input logic [1:0] bop, input logic ack);
        exp_t e;
        @(posedge clk); #1;
        cpu_valid = cv; cpu_op = cop; snp_valid = sv; snp_op = sop;
        bus_gnt = g; bus_shared_in = shin; bus_keep_fwd_in = kfin;
        e = '{tag, st, sh, sup, kf, wb, breq, bop, ack};
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag, input logic [2:0] st);
        cyc(0, 0, 0, 0, 0, 0, 0, tag, st, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle("R1 reset state", ST_I);
        // R4 read miss, no sharers -> E
        cyc(1, CPU_RD, 0, 0, 0, 0, 0, "R4 read miss request", ST_I, 0, 0, 0, 0, 1, BUS_RD, 0);
        cyc(1, CPU_RD, 0, 0, 1, 0, 0, "R4 grant", ST_I, 0, 0, 0, 0, 1, BUS_RD, 1);
        idle("R4 installed E", ST_E);
        // R3 snoop read on E
        cyc(0, 0, 1, BUS_RD, 0, 0, 0, "R3 snoop read on E", ST_E, 1, 1, 1, 0, 0, 0, 0);
        idle("R3 E became F", ST_F);
        // R2 snoop read on F then S
        cyc(0, 0, 1, BUS_RD, 0, 0, 0, "R2 snoop read on F", ST_F, 1, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, BUS_RD, 0, 0, 0, "R2 snoop read on S", ST_S, 1, 0, 0, 0, 0, 0, 0);
        idle("R2 S stays S", ST_S);
        // R9 write in S collides with snooped read-exclusive
        cyc(1, CPU_WR, 1, BUS_RDX, 0, 0, 0, "R9 write+snoop same cycle", ST_S, 0, 0, 0, 0, 1, BUS_UPG, 0);
        cyc(1, CPU_WR, 0, 0, 0, 0, 0, "R9 upgrade reissued as rdx", ST_I, 0, 0, 0, 0, 1, BUS_RDX, 0);
        cyc(1, CPU_WR, 0, 0, 1, 0, 0, "R9 rdx grant", ST_I, 0, 0, 0, 0, 1, BUS_RDX, 1);
        idle("R5 write miss ends M", ST_M);
        // R3 snoop read on M
        cyc(0, 0, 1, BUS_RD, 0, 0, 0, "R3 snoop read on M", ST_M, 1, 1, 1, 1, 0, 0, 0);
        idle("R3 M became F", ST_F);
        // R8 demote
        cyc(1, CPU_DM, 0, 0, 0, 0, 0, "R8 demote F", ST_F, 0, 0, 0, 0, 0, 0, 1);
        idle("R8 F became S", ST_S);
        // R6 snoop upgrade on S
        cyc(0, 0, 1, BUS_UPG, 0, 0, 0, "R6 snoop upgrade on S", ST_S, 0, 0, 0, 0, 0, 0, 0);
        idle("R6 S invalidated", ST_I);
        // R4 fill with owner keeping forwarder -> S
        cyc(1, CPU_RD, 0, 0, 1, 1, 1, "R4 grant shared keepfwd", ST_I, 0, 0, 0, 0, 1, BUS_RD, 1);
        idle("R4 installed S", ST_S);
        // R5 upgrade from S
        cyc(1, CPU_WR, 0, 0, 0, 0, 0, "R5 upgrade request", ST_S, 0, 0, 0, 0, 1, BUS_UPG, 0);
        cyc(1, CPU_WR, 0, 0, 1, 0, 0, "R5 upgrade grant", ST_S, 0, 0, 0, 0, 1, BUS_UPG, 1);
        idle("R5 S became M", ST_M);
        // R6 snoop rdx on M
        cyc(0, 0, 1, BUS_RDX, 0, 0, 0, "R6 snoop rdx on M", ST_M, 0, 1, 0, 0, 0, 0, 0);
        idle("R6 M invalidated", ST_I);
        // R4 fill with sharers but no forwarder kept -> F
        cyc(1, CPU_RD, 0, 0, 1, 1, 0, "R4 grant shared only", ST_I, 0, 0, 0, 0, 1, BUS_RD, 1);
        idle("R4 installed F", ST_F);
        // R7 evict F: no writeback
        cyc(1, CPU_EV, 0, 0, 0, 0, 0, "R7 evict F", ST_F, 0, 0, 0, 0, 0, 0, 1);
        idle("R7 F evicted", ST_I);
        // R5 local write in E, R7 evict M
        cyc(1, CPU_RD, 0, 0, 1, 0, 0, "R4 grant exclusive", ST_I, 0, 0, 0, 0, 1, BUS_RD, 1);
        cyc(1, CPU_WR, 0, 0, 0, 0, 0, "R5 write E local", ST_E, 0, 0, 0, 0, 0, 0, 1);
        cyc(1, CPU_EV, 0, 0, 0, 0, 0, "R7 evict M writes back", ST_M, 0, 0, 0, 1, 0, 0, 1);
        idle("R7 M evicted", ST_I);
        // R5 write miss
        cyc(1, CPU_WR, 0, 0, 1, 0, 0, "R5 write miss grant", ST_I, 0, 0, 0, 0, 1, BUS_RDX, 1);
        // R9 read hit in M collides with snooped read
        cyc(1, CPU_RD, 1, BUS_RD, 0, 0, 0, "R9 read hit+snoop same cycle", ST_M, 1, 1, 1, 1, 0, 0, 0);
        cyc(1, CPU_RD, 0, 0, 0, 0, 0, "R9 read hit after snoop", ST_F, 0, 0, 0, 0, 0, 0, 1);
        // R8 demote outside F has no effect
        cyc(1, CPU_WR, 0, 0, 0, 0, 0, "R5 upgrade from F", ST_F, 0, 0, 0, 0, 1, BUS_UPG, 0);
        cyc(1, CPU_WR, 0, 0, 1, 0, 0, "R5 upgrade from F grant", ST_F, 0, 0, 0, 0, 1, BUS_UPG, 1);
        cyc(1, CPU_DM, 0, 0, 0, 0, 0, "R8 demote M", ST_M, 0, 0, 0, 0, 0, 0, 1);
        idle("R8 M unchanged", ST_M);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 5000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule